// File: doc/BRIEF.md
# Sequential-Access Scratch RAM Port

This block is a small scratch memory that sits on an 8-bit processor bus and is reached through a single decoded device-select code. The processor never presents an address. An internal pointer names the word in use, and it steps forward by one after every completed access. A program therefore pours a run of bytes in with repeated stores and pulls them back out in the same order with repeated fetches.

An access is one select pulse: the bus-cycle strobe high while the device-select lines carry the block's code. The read/write line picks the direction. High stores the bus byte at the pointer, and low drives the stored byte onto the bus for as long as the pulse lasts. The pointer moves on the clock edge that follows the end of the pulse, so every clock of a pulse sees the same word. A synchronous clear input returns the pointer to zero to begin a new run.

Top module: `seqram_port`

## Requirements
- R1: After reset is released the pointer is zero, so the first access after reset uses word 0. Memory contents are not changed by reset.
- R2: While `cyc_stb` is 1, `dev_sel` equals `SEL_CODE` (default 4'd1) and `rw_wr` is 1, the byte on `data_io` is stored at the pointer.
- R3: While `cyc_stb` is 1, `dev_sel` equals `SEL_CODE` and `rw_wr` is 0, the block drives the word at the pointer onto `data_io`.
- R4: The block releases `data_io` to high impedance whenever it is not selected for a read, including during its own writes and during pulses for other select codes.
- R5: The pointer advances by exactly one on the first clock edge at which the select pulse is found low after being high. A pulse of several cycles uses a single address throughout and advances the pointer only once.
- R6: The pointer wraps from the last word (255 by default) to word 0.
- R7: `ptr_clr` high at a clock edge sets the pointer to zero. If it coincides with the end of a select pulse, the clear wins and the pointer is 0, not 1.
- R8: A pulse with any other select code, or select lines carrying the code while `cyc_stb` is low, neither stores data nor moves the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 4 | Device-select code |
| rw_wr | input | 1 | 1 = store, 0 = fetch |
| cyc_stb | input | 1 | Bus-cycle strobe |
| ptr_clr | input | 1 | Synchronous pointer clear |
| data_io | inout | 8 | Bidirectional data bus |

## Verification
Pointer advance and pointer clear can land on the same clock edge. This happens when a clear is raised in the very cycle that a select pulse ends. The bench provokes it by raising `ptr_clr` at the same falling edge where it drops the strobe. It then judges the result at the ports: the next fetch must return word 0 rather than word 1. A second case holds one read pulse over several cycles and checks that the bus value is unchanged across the pulse and that the pointer moves only once afterwards.

// File: rtl/seqram_port.sv
module seqram_port #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int SW = 4,
  parameter logic [SW-1:0] SEL_CODE = 4'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] dev_sel,
  input  logic          rw_wr,
  input  logic          cyc_stb,
  input  logic          ptr_clr,
  inout  wire  [DW-1:0] data_io
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic          sel_q;
  logic          sel_now;
  logic          pulse_end;

  assign sel_now   = cyc_stb && (dev_sel == SEL_CODE);
  assign pulse_end = sel_q && !sel_now;

  always_ff @(posedge clk) begin
    if (sel_now && rw_wr) mem[ptr_q] <= data_io;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_now;
      if (ptr_clr)        ptr_q <= '0;
      else if (pulse_end) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign data_io = (sel_now && !rw_wr) ? mem[ptr_q] : 'z;
endmodule

// File: rtl/seqram_port_chk.sv
module seqram_port_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_now,
  input logic          sel_q,
  input logic          ptr_clr,
  input logic [AW-1:0] ptr
);
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel_now && !ptr_clr) |=> ptr == AW'($past(ptr) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel_q && !sel_now) && !ptr_clr) |=> $stable(ptr));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> ptr == '0);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_clr && sel_q && !sel_now) |=> ptr == '0);

  p_long_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && sel_now && !ptr_clr) |=> $stable(ptr));
endmodule

bind seqram_port seqram_port_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_now(sel_now), .sel_q(sel_q),
  .ptr_clr(ptr_clr), .ptr(ptr_q)
);

// File: tb/seqram_port_tb_top.sv
module seqram_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dev_sel = 4'd0;
  logic       rw_wr = 1'b0;
  logic       cyc_stb = 1'b0;
  logic       ptr_clr = 1'b0;
  logic [7:0] tb_drv = 8'h00;
  logic       tb_oe = 1'b0;
  wire  [7:0] bus;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign bus = tb_oe ? tb_drv : 'z;
  always #2.5 clk = ~clk;

  seqram_port dut_i (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .rw_wr(rw_wr),
    .cyc_stb(cyc_stb), .ptr_clr(ptr_clr), .data_io(bus)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(logic [7:0] d, logic [3:0] code = 4'd1);
    @(negedge clk);
    dev_sel = code; rw_wr = 1'b1; cyc_stb = 1'b1; tb_drv = d; tb_oe = 1'b1;
    #1 chk("R4 bus not driven by block during write", bus, d);
    @(negedge clk);
    cyc_stb = 1'b0; tb_oe = 1'b0; dev_sel = 4'd0;
    @(negedge clk);
  endtask

  task automatic rd_byte(string tag, logic [7:0] exp, int len = 1, bit clr_at_end = 1'b0);
    @(negedge clk);
    dev_sel = 4'd1; rw_wr = 1'b0; cyc_stb = 1'b1;
    for (int k = 0; k < len; k++) begin
      #1 chk(tag, bus, exp);
      @(negedge clk);
    end
    cyc_stb = 1'b0; dev_sel = 4'd0;
    if (clr_at_end) ptr_clr = 1'b1;
    @(negedge clk);
    ptr_clr = 1'b0;
  endtask

  task automatic clear_ptr();
    @(negedge clk); ptr_clr = 1'b1;
    @(negedge clk); ptr_clr = 1'b0;
  endtask

  task automatic t_fill_and_reset();
    for (int i = 0; i < 256; i++) wr_byte(pat(i));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_byte("R1 first fetch after reset uses word 0", pat(0));
  endtask

  task automatic t_stream_wrap();
    clear_ptr();
    for (int i = 0; i < 256; i++) rd_byte("R3 streamed fetch", pat(i));
    rd_byte("R6 pointer wraps to word 0", pat(0));
    rd_byte("R6 after wrap continues at word 1", pat(1));
  endtask

  task automatic t_long_pulse();
    clear_ptr();
    rd_byte("R5 long pulse keeps one address", pat(0), 4);
    rd_byte("R5 long pulse advanced only once", pat(1));
  endtask

  task automatic t_other_code();
    clear_ptr();
    wr_byte(8'hEE, 4'd6);
    @(negedge clk);
    dev_sel = 4'd1; rw_wr = 1'b1; cyc_stb = 1'b0; tb_drv = 8'hDD; tb_oe = 1'b1;
    @(negedge clk);
    tb_oe = 1'b0; dev_sel = 4'd0;
    @(negedge clk);
    rd_byte("R8 foreign code and idle strobe leave word 0 and pointer", pat(0));
    rd_byte("R8 next word still in order", pat(1));
  endtask

  task automatic t_release();
    clear_ptr();
    @(negedge clk);
    tb_drv = 8'h00; tb_oe = 1'b1; dev_sel = 4'd1; rw_wr = 1'b0; cyc_stb = 1'b0;
    #1 chk("R4 bus released while idle", bus, 8'h00);
    @(negedge clk);
    dev_sel = 4'd5; cyc_stb = 1'b1;
    #1 chk("R4 bus released for other code read", bus, 8'h00);
    @(negedge clk);
    cyc_stb = 1'b0; dev_sel = 4'd0; tb_oe = 1'b0;
    @(negedge clk);
    rd_byte("R2 stored word readable after release test", pat(0));
  endtask

  task automatic t_clear_collision();
    clear_ptr();
    rd_byte("R7 fetch before colliding clear", pat(0), 1, 1'b1);
    rd_byte("R7 clear wins over advance", pat(0));
    rd_byte("R3 fetch word 1", pat(1));
    rd_byte("R3 fetch word 2", pat(2));
    clear_ptr();
    rd_byte("R7 plain clear restarts run", pat(0));
  endtask

  task automatic t_overwrite();
    clear_ptr();
    wr_byte(8'h5A);
    wr_byte(8'hA5);
    clear_ptr();
    rd_byte("R2 overwrite word 0", 8'h5A);
    rd_byte("R2 overwrite word 1", 8'hA5);
    rd_byte("R2 word 2 untouched", pat(2));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_fill_and_reset();
    t_stream_wrap();
    t_long_pulse();
    t_other_code();
    t_release();
    t_clear_collision();
    t_overwrite();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(5ns * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule